// File: doc/BRIEF.md
# Serial Flash Hold and Status-Write Guard

This block sits in front of the command and shift core of a serial flash slave and runs on a fast system clock. It brings the chip-select, serial clock, pause and write-protect pins into the clock domain through a synchronizer chain. From the synchronized values it produces one-cycle qualifiers for the serial clock's rising and falling edges, and the core uses these to advance its bit counter and shift register.

When the pause pin is driven low while the device is selected, the block enters a paused state. A pause request only takes effect while the serial clock is low, so a pause pin edge that arrives while the clock is high waits for the clock to fall. The same deferral applies when the pause ends. While paused, no edge qualifiers reach the core, so the transfer in progress resumes exactly where it stopped, and the data-out driver is disabled. Deselecting the device clears the pause and emits a one-cycle interface reset for the core. The pause function is only honoured when the core reports a one- or two-lane transfer mode.

The block also owns the protection bits of the status register: three block-protect bits and a lock bit. The core raises a write request with the new value, and one cycle later the block answers with either a grant or a refusal. The decision combines the write-protect pin with the lock bit.

Top module: `sflash_hold_guard`

## Requirements
- R1: Each pin passes through SYNC_STAGES flops. `sck_rise_en` pulses for one cycle per synchronized rising edge of the serial clock while `cs_active` is 1 and `held` is 0. It never pulses while the device is deselected.
- R2: `sck_fall_en` pulses for one cycle per synchronized falling edge of the serial clock, but only when the block is unpaused both before and after that edge. The falling edge that starts or ends a pause produces no pulse.
- R3: With `cs_active` = 1 and `hold_allow` = 1, a low level on `hold_n_pin` seen while the synchronized clock is low sets `held`. If the clock is high at that point, `held` stays 0 until the clock next goes low.
- R4: A high level on `hold_n_pin` seen while the clock is low clears `held`. If the clock is high, `held` stays 1 until the clock next goes low.
- R5: While `held` is 1, serial clock toggles produce neither `sck_rise_en` nor `sck_fall_en`. `held` stays 1 for as long as `hold_n_pin` stays low.
- R6: `so_oe` equals `core_so_oe` when the device is selected and not paused. It is 0 whenever `held` is 1 or the device is deselected.
- R7: A rising edge of synchronized `ce_n_pin` clears `held` and pulses `iface_rst` for exactly one cycle. After reset no spurious pulse occurs.
- R8: When `hold_allow` is 0, `hold_n_pin` has no effect: `held` stays 0 and edge qualifiers continue.
- R9: `status` resets to 0x00. Only bit 7 (lock) and bits 4:2 (block-protect) are stored. All other bits read 0.
- R10: One cycle after `wrsr_req`, the block either asserts `wrsr_grant` and loads the masked `wrsr_data` into `status`, or asserts `wrsr_deny` and leaves `status` unchanged. The request is refused only when synchronized `wp_n_pin` is 0 and status bit 7 is 1. Grant and deny are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n_pin | input | 1 | Chip select pin, active low, asynchronous |
| sck_pin | input | 1 | Serial clock pin, asynchronous |
| hold_n_pin | input | 1 | Pause pin, active low, asynchronous |
| wp_n_pin | input | 1 | Write-protect pin, active low, asynchronous |
| hold_allow | input | 1 | 1 when the core is in one- or two-lane mode |
| core_so_oe | input | 1 | Data-out enable requested by the core |
| wrsr_req | input | 1 | One-cycle status write request |
| wrsr_data | input | SR_W | Value to write into the status register |
| cs_active | output | 1 | Synchronized device-selected level |
| held | output | 1 | Paused state |
| sck_rise_en | output | 1 | Qualified rising-edge pulse |
| sck_fall_en | output | 1 | Qualified falling-edge pulse |
| so_oe | output | 1 | Gated data-out enable |
| iface_rst | output | 1 | One-cycle interface reset on deselect |
| status | output | SR_W | Status register |
| wrsr_grant | output | 1 | Status write accepted |
| wrsr_deny | output | 1 | Status write refused |

## Verification
The bench builds the block with its defaults: a two-flop synchronizer, an 8-bit status register, the lock bit at bit 7 and three protect bits at bits 4:2. The short synchronizer keeps each pin change visible within a few system cycles, so waiting four cycles is enough to reach every deferred pause entry and exit. The 8-bit width puts both the masked-off bits and every combination of protect pin and lock bit within reach of a handful of write vectors.

// File: rtl/sflash_hold_guard.sv
module sflash_hold_guard #(
  parameter int SYNC_STAGES = 2,
  parameter int SR_W        = 8,
  parameter int LOCK_BIT    = 7,
  parameter int BP_LSB      = 2,
  parameter int BP_W        = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ce_n_pin,
  input  logic            sck_pin,
  input  logic            hold_n_pin,
  input  logic            wp_n_pin,
  input  logic            hold_allow,
  input  logic            core_so_oe,
  input  logic            wrsr_req,
  input  logic [SR_W-1:0] wrsr_data,
  output logic            cs_active,
  output logic            held,
  output logic            sck_rise_en,
  output logic            sck_fall_en,
  output logic            so_oe,
  output logic            iface_rst,
  output logic [SR_W-1:0] status,
  output logic            wrsr_grant,
  output logic            wrsr_deny
);
  localparam logic [SR_W-1:0] BP_MASK   = SR_W'(((1 << BP_W) - 1) << BP_LSB);
  localparam logic [SR_W-1:0] LOCK_MASK = SR_W'(1) << LOCK_BIT;
  localparam logic [SR_W-1:0] SR_MASK   = BP_MASK | LOCK_MASK;
  localparam logic [3:0]      PIN_IDLE  = 4'b1101;

  logic [SYNC_STAGES-1:0][3:0] sync_q;
  logic wp_s, hold_n_s, sck_s, ce_n_s;
  logic sck_q, ce_q;
  logic hold_next, sck_up, sck_dn, wrsr_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= {SYNC_STAGES{PIN_IDLE}};
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], {wp_n_pin, hold_n_pin, sck_pin, ce_n_pin}};

  assign {wp_s, hold_n_s, sck_s, ce_n_s} = sync_q[SYNC_STAGES-1];
  assign cs_active = ~ce_n_s;

  assign hold_next = cs_active & hold_allow & (sck_s ? held : ~hold_n_s);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held  <= 1'b0;
      sck_q <= 1'b0;
      ce_q  <= 1'b1;
    end else begin
      held  <= hold_next;
      sck_q <= sck_s;
      ce_q  <= ce_n_s;
    end

  assign sck_up      = sck_s & ~sck_q;
  assign sck_dn      = ~sck_s & sck_q;
  assign sck_rise_en = sck_up & cs_active & ~held;
  assign sck_fall_en = sck_dn & cs_active & ~held & ~hold_next;
  assign so_oe       = core_so_oe & cs_active & ~held;
  assign iface_rst   = ce_n_s & ~ce_q;

  assign wrsr_ok = wp_s | ~status[LOCK_BIT];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status     <= '0;
      wrsr_grant <= 1'b0;
      wrsr_deny  <= 1'b0;
    end else begin
      wrsr_grant <= wrsr_req & wrsr_ok;
      wrsr_deny  <= wrsr_req & ~wrsr_ok;
      if (wrsr_req && wrsr_ok) status <= wrsr_data & SR_MASK;
    end

  // R3
  hold_entry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> (!$past(sck_s) && !$past(ce_n_s) && $past(hold_allow)));

  // R4
  hold_exit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> (!$past(sck_s) || $past(ce_n_s) || !$past(hold_allow)));

  // R6
  so_off_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  // R7
  deselect_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n_s |=> !held);

  // R8
  mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_allow |=> !held);

  // R9
  status_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & ~SR_MASK) == '0);

  // R10
  locked_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_req && !wp_s && status[LOCK_BIT]) |=> (wrsr_deny && status == $past(status)));

  // R10
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrsr_grant && wrsr_deny));

  // R10
  status_only_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> wrsr_grant);
endmodule

// File: tb/sflash_hold_guard_test.sv
`timescale 1ns/1ps
module sflash_hold_guard_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n_pin = 1'b1, sck_pin = 1'b0, hold_n_pin = 1'b1, wp_n_pin = 1'b1;
  logic hold_allow = 1'b1, core_so_oe = 1'b1, wrsr_req = 1'b0;
  logic [7:0] wrsr_data = 8'h00;
  logic cs_active, held, sck_rise_en, sck_fall_en, so_oe, iface_rst, wrsr_grant, wrsr_deny;
  logic [7:0] status;

  int n_chk = 0, n_bad = 0, n_rise = 0, n_fall = 0, n_rst = 0, cyc = 0;
  int e_rise = 0, e_fall = 0;

  always #4 clk = ~clk;

  sflash_hold_guard uut (.*);

  always @(posedge clk) begin
    if (sck_rise_en) n_rise++;
    if (sck_fall_en) n_fall++;
    if (iface_rst)   n_rst++;
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sck_cycle();
    sck_pin = 1'b1; wait_n(4);
    sck_pin = 1'b0; wait_n(4);
  endtask

  // {wp_n, data, grant, expected status}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 8'h9C, 1'b1, 8'h9C},
    {1'b0, 8'h00, 1'b0, 8'h9C},
    {1'b1, 8'h84, 1'b1, 8'h84},
    {1'b0, 8'h10, 1'b0, 8'h84},
    {1'b1, 8'h7F, 1'b1, 8'h1C},
    {1'b0, 8'hFF, 1'b1, 8'h9C},
    {1'b0, 8'h00, 1'b0, 8'h9C},
    {1'b1, 8'h00, 1'b1, 8'h00}
  };

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    chk("R9 reset status", status, 8'h00);
    chk("R6 reset so_oe", so_oe, 0);
    chk("R3 reset held", held, 0);
    chk("R7 no reset pulse after reset", n_rst, 0);

    for (int i = 0; i < 8; i++) begin
      wp_n_pin = VEC[i][17];
      wait_n(4);
      wrsr_req  = 1'b1;
      wrsr_data = VEC[i][16:9];
      @(negedge clk);
      wrsr_req = 1'b0;
      chk($sformatf("R10 vec%0d grant", i), wrsr_grant, VEC[i][8]);
      chk($sformatf("R10 vec%0d deny", i), wrsr_deny, !VEC[i][8]);
      chk($sformatf("R9 R10 vec%0d status", i), status, VEC[i][7:0]);
    end

    sck_cycle();
    chk("R1 no rise while deselected", n_rise, 0);

    ce_n_pin = 1'b0; wait_n(4);
    chk("R6 so_oe selected", so_oe, 1);
    for (int i = 0; i < 8; i++) sck_cycle();
    e_rise = 8; e_fall = 8;
    chk("R1 rise count", n_rise, e_rise);
    chk("R2 fall count", n_fall, e_fall);

    hold_n_pin = 1'b0; wait_n(4);
    chk("R3 hold with clock low", held, 1);
    chk("R6 so_oe in hold", so_oe, 0);
    for (int i = 0; i < 4; i++) sck_cycle();
    chk("R5 rises ignored in hold", n_rise, e_rise);
    chk("R5 falls ignored in hold", n_fall, e_fall);
    chk("R5 hold persists", held, 1);

    sck_pin = 1'b1; wait_n(4);
    hold_n_pin = 1'b1; wait_n(4);
    chk("R4 exit deferred while clock high", held, 1);
    sck_pin = 1'b0; wait_n(4);
    chk("R4 exit at clock low", held, 0);
    chk("R2 exit fall suppressed", n_fall, e_fall);
    sck_cycle(); e_rise++; e_fall++;
    chk("R1 resume rise", n_rise, e_rise);

    sck_pin = 1'b1; wait_n(4); e_rise++;
    hold_n_pin = 1'b0; wait_n(4);
    chk("R3 entry deferred while clock high", held, 0);
    sck_pin = 1'b0; wait_n(4);
    chk("R3 entry at clock low", held, 1);
    chk("R2 entry fall suppressed", n_fall, e_fall);

    ce_n_pin = 1'b1; wait_n(4);
    chk("R7 deselect clears hold", held, 0);
    chk("R7 one reset pulse", n_rst, 1);
    hold_n_pin = 1'b1;
    ce_n_pin = 1'b0; wait_n(4);

    hold_allow = 1'b0;
    hold_n_pin = 1'b0; wait_n(4);
    chk("R8 hold ignored in other mode", held, 0);
    sck_cycle(); e_rise++; e_fall++;
    chk("R8 rises continue", n_rise, e_rise);
    chk("R8 falls continue", n_fall, e_fall);
    hold_n_pin = 1'b1; hold_allow = 1'b1;

    ce_n_pin = 1'b1; wait_n(4);
    chk("R6 so_oe deselected", so_oe, 0);
    chk("R7 second reset pulse", n_rst, 2);
    sck_cycle();
    chk("R1 no rise after deselect", n_rise, e_rise);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule